// File: doc/BRIEF.md
# Interrupt Active-Priority Register Bank

This block keeps track of which preemption levels have an interrupt in service, for one interrupt group of a virtualised interrupt controller. Every implemented preemption level has one bit, and the bits are grouped into 32-bit words. A build-time parameter sets how many preemption bits exist (5, 6 or 7). That parameter fixes the number of levels at 32, 64 or 128 and the number of words at one, two or four. Interrupt-handling logic uses the set and clear ports, which take an 8-bit priority, to mark a level as active when an interrupt is acknowledged and inactive when its handling completes.

Software reaches the words through system-register style read and write requests. Each request carries a word index, the exception level it comes from, and the state of the trap and enable controls. The block answers every request one cycle later. The answer is one of three outcomes: it completes, it is trapped to the hypervisor with a syndrome code, or it is refused as undefined. The block also reports continuously the most urgent active priority, which is the lowest active level index, together with a flag that says whether any level is active.

Top module: `actprio_bank`

## Requirements
- R1: After synchronous reset every word is zero, `top_valid` is 0 and `rsp_valid` is 0. Reads that complete after reset return 0.
- R2: The number of words is 2^(PRE_BITS-5). A request whose `acc_idx` (the two low bits of the access-encoding opc2 field) is not below that count is answered undefined, whatever its level or controls.
- R3: A request from exception level 0 (`acc_el` = 2'b00) is answered undefined.
- R4: A request from level 1 (`acc_el` = 2'b01) to an existing word is trapped (code 2'b01, `rsp_ec` = 6'h03) when `el2_enabled` and `el2_trap_en` are both 1. Otherwise it is answered undefined.
- R5: A request from level 2 (2'b10) or level 3 (2'b11) to an existing word completes when `sysreg_en_el2` or `sysreg_en_el3` respectively is 1. Otherwise it is undefined.
- R6: Every request made while `acc_valid` is high gets exactly one response, with `rsp_valid` high on the next cycle. The codes are 2'b00 complete, 2'b01 trap and 2'b10 undefined. A completed read returns the word's value as it stood in the request cycle.
- R7: A response that did not complete has `rsp_rdata` = 0. A write that does not complete leaves every word unchanged.
- R8: A completed write replaces the whole selected word, and the new value can be read from the following cycle.
- R9: A set or clear request addresses level L = priority[7 : 8-PRE_BITS]. Level L is held in word L/32 at bit L mod 32.
- R10: When a set and a clear address the same level in one cycle, the clear wins. A completed write to a word overrides any set or clear aimed at that word in the same cycle. Sets and clears aimed at other words still apply.
- R11: `top_valid` is 1 exactly when some bit is set. `top_prio` is then the lowest set level L shifted left by 8-PRE_BITS, and it is 0 when no bit is set.
- R12: Priority bits below the implemented preemption bits are ignored. For example, with 6 bits the priorities 8'h13 and 8'h10 address the same level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Register access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_idx | input | 2 | Word index (opc2 low bits) |
| acc_el | input | 2 | Exception level of the requester |
| acc_wdata | input | 32 | Write data |
| el2_enabled | input | 1 | Hypervisor level is enabled |
| el2_trap_en | input | 1 | Hypervisor trap control for these registers |
| sysreg_en_el2 | input | 1 | System-register interface enable for level 2 |
| sysreg_en_el3 | input | 1 | System-register interface enable for level 3 |
| set_valid | input | 1 | Mark a level active |
| set_prio | input | 8 | Priority whose level is marked active |
| clr_valid | input | 1 | Mark a level inactive |
| clr_prio | input | 8 | Priority whose level is marked inactive |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_code | output | 2 | 00 complete, 01 trap, 10 undefined |
| rsp_ec | output | 6 | Trap syndrome code, 6'h03 on trap, else 0 |
| rsp_rdata | output | 32 | Read data, 0 unless a completed read |
| top_valid | output | 1 | Some level is active |
| top_prio | output | 8 | Most urgent active priority |

## Verification
The bench builds two copies of the block. The main copy uses six preemption bits. With two words present and two missing, it reaches the missing-word refusal, levels that cross from word 0 into word 1, and the search for the lowest level across a word boundary. It also covers every exception-level and control combination and the same-cycle conflicts between writes, sets and clears. A second copy with five bits checks that a single word exists, that index 1 is refused, and that the three low priority bits are dropped.

// File: rtl/actprio_pkg.sv
package actprio_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned PRIO_W = 8;
    localparam logic [5:0]  TRAP_EC = 6'h03;

    typedef enum logic [1:0] {
        RSP_OK    = 2'b00,
        RSP_TRAP  = 2'b01,
        RSP_UNDEF = 2'b10
    } rsp_code_e;

    typedef enum logic [1:0] {
        LVL_EL0 = 2'b00,
        LVL_EL1 = 2'b01,
        LVL_EL2 = 2'b10,
        LVL_EL3 = 2'b11
    } exc_lvl_e;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [1:0]        idx;
        exc_lvl_e          el;
        logic [WORD_W-1:0] wdata;
    } acc_req_t;

    typedef struct packed {
        logic el2_en;
        logic trap_en;
        logic sre_el2;
        logic sre_el3;
    } acc_ctl_t;

    typedef struct packed {
        logic              valid;
        rsp_code_e         code;
        logic [5:0]        ec;
        logic [WORD_W-1:0] rdata;
    } acc_rsp_t;

    // Number of words needed for a given count of preemption bits.
    function automatic int unsigned words_for(input int unsigned pre_bits);
        return (1 << pre_bits) / WORD_W;
    endfunction

endpackage

// File: rtl/actprio_access_decode.sv
module actprio_access_decode
    import actprio_pkg::*;
#(
    parameter int unsigned NUM_WORDS = 4
) (
    input  acc_req_t  req,
    input  acc_ctl_t  ctl,
    output rsp_code_e code,
    output logic [5:0] ec
);
    localparam logic [2:0] WORDS3 = 3'(NUM_WORDS);

    logic present;
    assign present = ({1'b0, req.idx} < WORDS3);

    always_comb begin
        code = RSP_UNDEF;
        ec   = '0;
        if (present) begin
            unique case (req.el)
                LVL_EL0: code = RSP_UNDEF;
                LVL_EL1: begin
                    if (ctl.el2_en && ctl.trap_en) begin
                        code = RSP_TRAP;
                        ec   = TRAP_EC;
                    end
                end
                LVL_EL2: if (ctl.sre_el2) code = RSP_OK;
                LVL_EL3: if (ctl.sre_el3) code = RSP_OK;
                default: code = RSP_UNDEF;
            endcase
        end
    end
endmodule

// File: rtl/actprio_level_mask.sv
module actprio_level_mask
    import actprio_pkg::*;
#(
    parameter int unsigned PRE_BITS = 7
) (
    input  logic                     valid,
    input  logic [PRIO_W-1:0]        prio,
    output logic [(1<<PRE_BITS)-1:0] mask
);
    localparam int unsigned NUM_LEVELS = 1 << PRE_BITS;

    logic [PRE_BITS-1:0] level;
    assign level = prio[PRIO_W-1 -: PRE_BITS];

    always_comb begin
        for (int l = 0; l < NUM_LEVELS; l++) begin
            mask[l] = valid && (level == PRE_BITS'(l));
        end
    end
endmodule

// File: rtl/actprio_find_lowest.sv
module actprio_find_lowest
    import actprio_pkg::*;
#(
    parameter int unsigned PRE_BITS = 7
) (
    input  logic [(1<<PRE_BITS)-1:0] bits,
    output logic                     any,
    output logic [PRIO_W-1:0]        prio
);
    localparam int unsigned NUM_LEVELS = 1 << PRE_BITS;
    localparam int unsigned LOW_W      = PRIO_W - PRE_BITS;

    logic [PRE_BITS-1:0] lvl;

    always_comb begin
        lvl = '0;
        for (int l = NUM_LEVELS - 1; l >= 0; l--) begin
            if (bits[l]) lvl = PRE_BITS'(l);
        end
    end

    assign any  = |bits;
    assign prio = any ? {lvl, {LOW_W{1'b0}}} : '0;
endmodule

// File: rtl/actprio_bank.sv
module actprio_bank
    import actprio_pkg::*;
#(
    parameter int unsigned PRE_BITS = 7
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic [1:0]  acc_idx,
    input  logic [1:0]  acc_el,
    input  logic [31:0] acc_wdata,
    input  logic        el2_enabled,
    input  logic        el2_trap_en,
    input  logic        sysreg_en_el2,
    input  logic        sysreg_en_el3,
    input  logic        set_valid,
    input  logic [7:0]  set_prio,
    input  logic        clr_valid,
    input  logic [7:0]  clr_prio,
    output logic        rsp_valid,
    output logic [1:0]  rsp_code,
    output logic [5:0]  rsp_ec,
    output logic [31:0] rsp_rdata,
    output logic        top_valid,
    output logic [7:0]  top_prio
);
    localparam int unsigned NUM_LEVELS = 1 << PRE_BITS;
    localparam int unsigned NUM_WORDS  = words_for(PRE_BITS);

    acc_req_t  req;
    acc_ctl_t  ctl;
    acc_rsp_t  rsp_q;
    rsp_code_e acc_code;
    logic [5:0] acc_ec;

    logic [WORD_W-1:0]     word_q [NUM_WORDS];
    logic [NUM_LEVELS-1:0] bank_flat;
    logic [NUM_LEVELS-1:0] set_mask;
    logic [NUM_LEVELS-1:0] clr_mask;
    logic [WORD_W-1:0]     rd_word;

    assign req = '{valid: acc_valid, write: acc_write, idx: acc_idx,
                   el: exc_lvl_e'(acc_el), wdata: acc_wdata};
    assign ctl = '{el2_en: el2_enabled, trap_en: el2_trap_en,
                   sre_el2: sysreg_en_el2, sre_el3: sysreg_en_el3};

    actprio_access_decode #(.NUM_WORDS(NUM_WORDS)) u_decode (
        .req  (req),
        .ctl  (ctl),
        .code (acc_code),
        .ec   (acc_ec)
    );

    actprio_level_mask #(.PRE_BITS(PRE_BITS)) u_set_mask (
        .valid (set_valid),
        .prio  (set_prio),
        .mask  (set_mask)
    );

    actprio_level_mask #(.PRE_BITS(PRE_BITS)) u_clr_mask (
        .valid (clr_valid),
        .prio  (clr_prio),
        .mask  (clr_mask)
    );

    // One storage word per implemented group of 32 levels.
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic wr_hit;
        assign wr_hit = req.valid && req.write && (acc_code == RSP_OK)
                        && (req.idx == 2'(w));

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q[w] <= '0;
            end else if (wr_hit) begin
                word_q[w] <= req.wdata;
            end else begin
                word_q[w] <= (word_q[w] | set_mask[w*WORD_W +: WORD_W])
                             & ~clr_mask[w*WORD_W +: WORD_W];
            end
        end

        assign bank_flat[w*WORD_W +: WORD_W] = word_q[w];
    end

    always_comb begin
        rd_word = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (req.idx == 2'(w)) rd_word = word_q[w];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '{valid: 1'b0, code: RSP_OK, ec: '0, rdata: '0};
        end else begin
            rsp_q.valid <= req.valid;
            rsp_q.code  <= req.valid ? acc_code : RSP_OK;
            rsp_q.ec    <= req.valid ? acc_ec : '0;
            rsp_q.rdata <= (req.valid && !req.write && acc_code == RSP_OK)
                           ? rd_word : '0;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_code  = rsp_q.code;
    assign rsp_ec    = rsp_q.ec;
    assign rsp_rdata = rsp_q.rdata;

    actprio_find_lowest #(.PRE_BITS(PRE_BITS)) u_find (
        .bits (bank_flat),
        .any  (top_valid),
        .prio (top_prio)
    );
endmodule

// File: rtl/actprio_bank_chk.sv
module actprio_bank_chk
    import actprio_pkg::*;
#(
    parameter int unsigned PRE_BITS = 7
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     acc_valid,
    input logic                     acc_write,
    input logic [1:0]               acc_idx,
    input logic [1:0]               acc_el,
    input logic [31:0]              acc_wdata,
    input logic                     el2_enabled,
    input logic                     el2_trap_en,
    input logic                     set_valid,
    input logic                     clr_valid,
    input logic                     rsp_valid,
    input logic [1:0]               rsp_code,
    input logic [5:0]               rsp_ec,
    input logic [31:0]              rsp_rdata,
    input logic                     top_valid,
    input logic [1:0]               acc_code,
    input logic [(1<<PRE_BITS)-1:0] bank_flat
);
    localparam logic [2:0] WORDS3 = 3'(words_for(PRE_BITS));

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rsp_valid && !top_valid));

    assert_missing_word_R2: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && ({1'b0, acc_idx} >= WORDS3)) |=> (rsp_valid && rsp_code == 2'b10));

    assert_el0_undef_R3: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_el == 2'b00) |=> (rsp_valid && rsp_code == 2'b10));

    assert_el1_trap_R4: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_el == 2'b01 && el2_enabled && el2_trap_en
         && ({1'b0, acc_idx} < WORDS3))
        |=> (rsp_code == 2'b01 && rsp_ec == 6'h03));

    assert_nonok_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code != 2'b00) |-> (rsp_rdata == '0));

    assert_nonok_write_R7: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && acc_code != 2'b00 && !set_valid && !clr_valid)
        |=> $stable(bank_flat));

    assert_ok_write_R8: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && acc_code == 2'b00 && acc_idx == 2'd0)
        |=> (bank_flat[31:0] == $past(acc_wdata)));

    assert_top_flag_R11: assert property (@(posedge clk) disable iff (rst)
        top_valid == (|bank_flat));
endmodule

bind actprio_bank actprio_bank_chk #(.PRE_BITS(PRE_BITS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .acc_valid   (acc_valid),
    .acc_write   (acc_write),
    .acc_idx     (acc_idx),
    .acc_el      (acc_el),
    .acc_wdata   (acc_wdata),
    .el2_enabled (el2_enabled),
    .el2_trap_en (el2_trap_en),
    .set_valid   (set_valid),
    .clr_valid   (clr_valid),
    .rsp_valid   (rsp_valid),
    .rsp_code    (rsp_code),
    .rsp_ec      (rsp_ec),
    .rsp_rdata   (rsp_rdata),
    .top_valid   (top_valid),
    .acc_code    (acc_code),
    .bank_flat   (bank_flat)
);

// File: tb/actprio_bank_tb.sv
`timescale 1ns/1ps
module actprio_bank_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    int nchk = 0;
    int nbad = 0;
    bit done = 1'b0;

    // Main copy: six preemption bits
    logic        a_v = 0, a_w = 0;
    logic [1:0]  a_idx = 0, a_el = 0;
    logic [31:0] a_wd = 0;
    logic        el2e = 0, trp = 0, s2 = 0, s3 = 0;
    logic        s_v = 0, c_v = 0;
    logic [7:0]  s_p = 0, c_p = 0;
    logic        r_v, t_v;
    logic [1:0]  r_code;
    logic [5:0]  r_ec;
    logic [31:0] r_data;
    logic [7:0]  t_p;

    actprio_bank #(.PRE_BITS(6)) u_dut (
        .clk(clk), .rst(rst), .acc_valid(a_v), .acc_write(a_w), .acc_idx(a_idx),
        .acc_el(a_el), .acc_wdata(a_wd), .el2_enabled(el2e), .el2_trap_en(trp),
        .sysreg_en_el2(s2), .sysreg_en_el3(s3), .set_valid(s_v), .set_prio(s_p),
        .clr_valid(c_v), .clr_prio(c_p), .rsp_valid(r_v), .rsp_code(r_code),
        .rsp_ec(r_ec), .rsp_rdata(r_data), .top_valid(t_v), .top_prio(t_p)
    );

    // Second copy: five preemption bits
    logic        f_v = 0, f_w = 0;
    logic [1:0]  f_idx = 0, f_el = 0;
    logic        fs_v = 0;
    logic [7:0]  fs_p = 0;
    logic        fr_v, ft_v;
    logic [1:0]  fr_code;
    logic [5:0]  fr_ec;
    logic [31:0] fr_data;
    logic [7:0]  ft_p;

    actprio_bank #(.PRE_BITS(5)) u_dut5 (
        .clk(clk), .rst(rst), .acc_valid(f_v), .acc_write(f_w), .acc_idx(f_idx),
        .acc_el(f_el), .acc_wdata(32'h0), .el2_enabled(1'b0), .el2_trap_en(1'b0),
        .sysreg_en_el2(1'b1), .sysreg_en_el3(1'b1), .set_valid(fs_v), .set_prio(fs_p),
        .clr_valid(1'b0), .clr_prio(8'h0), .rsp_valid(fr_v), .rsp_code(fr_code),
        .rsp_ec(fr_ec), .rsp_rdata(fr_data), .top_valid(ft_v), .top_prio(ft_p)
    );

    typedef struct {
        logic [1:0]  code;
        logic [5:0]  ec;
        logic [31:0] data;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    logic [31:0] model [2];

    function automatic logic [1:0] exp_code(input logic [1:0] idx, input logic [1:0] el,
                                            input int words);
        if (int'(idx) >= words) return 2'b10;
        case (el)
            2'b00:   return 2'b10;
            2'b01:   return (el2e && trp) ? 2'b01 : 2'b10;
            2'b10:   return s2 ? 2'b00 : 2'b10;
            default: return s3 ? 2'b00 : 2'b10;
        endcase
    endfunction

    // Monitor: compare every response against the scoreboard
    always @(negedge clk) begin
        if (!rst && r_v) begin
            nchk++;
            if (exp_q.size() == 0) begin
                nbad++;
                $display("FAIL %s: unexpected response code=%0b", "R6", r_code);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (r_code !== e.code || r_ec !== e.ec || r_data !== e.data) begin
                    nbad++;
                    $display("FAIL %s: got code=%0b ec=%h data=%h, expected code=%0b ec=%h data=%h",
                             e.tag, r_code, r_ec, r_data, e.code, e.ec, e.data);
                end
            end
        end
    end

    // Driver: one cycle of stimulus, with expected response and model update
    task automatic cyc(input logic av, input logic aw, input logic [1:0] idx,
                       input logic [1:0] el, input logic [31:0] wd,
                       input logic sv, input logic [7:0] sp,
                       input logic cv, input logic [7:0] cp, input string tag);
        logic [1:0] code;
        exp_t e;
        code = exp_code(idx, el, 2);
        a_v = av; a_w = aw; a_idx = idx; a_el = el; a_wd = wd;
        s_v = sv; s_p = sp; c_v = cv; c_p = cp;
        if (av) begin
            e.code = code;
            e.ec   = (code == 2'b01) ? 6'h03 : 6'h00;
            e.data = (!aw && code == 2'b00) ? model[idx[0]] : 32'h0;
            e.tag  = tag;
            exp_q.push_back(e);
        end
        for (int w = 0; w < 2; w++) begin
            if (av && aw && code == 2'b00 && int'(idx) == w) begin
                model[w] = wd;
            end else begin
                if (sv && int'(sp[7]) == w) model[w][sp[6:2]] = 1'b1;
                if (cv && int'(cp[7]) == w) model[w][cp[6:2]] = 1'b0;
            end
        end
        @(negedge clk);
        a_v = 0; a_w = 0; s_v = 0; c_v = 0;
    endtask

    task automatic acc(input logic aw, input logic [1:0] idx, input logic [1:0] el,
                       input logic [31:0] wd, input string tag);
        cyc(1'b1, aw, idx, el, wd, 1'b0, 8'h0, 1'b0, 8'h0, tag);
    endtask

    task automatic chk_top(input string tag);
        logic ev;
        logic [7:0] ep;
        ev = 1'b0;
        ep = 8'h0;
        for (int l = 63; l >= 0; l--) begin
            if (model[l / 32][l % 32]) begin
                ev = 1'b1;
                ep = 8'(l << 2);
            end
        end
        nchk++;
        if (t_v !== ev || t_p !== ep) begin
            nbad++;
            $display("FAIL %s: top valid=%0b prio=%h, expected valid=%0b prio=%h",
                     tag, t_v, t_p, ev, ep);
        end
    endtask

    task automatic chk5(input logic [31:0] act, input logic [31:0] expv, input string tag);
        nchk++;
        if (act !== expv) begin
            nbad++;
            $display("FAIL %s: got %h expected %h", tag, act, expv);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        model[0] = 0;
        model[1] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk5({31'b0, r_v}, 32'h0, "R1 rsp_valid");
        chk_top("R1 top after reset");
        s3 = 1'b1;
        acc(1'b0, 2'd0, 2'b11, 0, "R1 word0 reset");
        acc(1'b0, 2'd1, 2'b11, 0, "R1 word1 reset");

        // R5, R8, R6: completed writes and reads
        s2 = 1'b1;
        acc(1'b1, 2'd0, 2'b10, 32'hA5A5_0F00, "R5 el2 write");
        acc(1'b0, 2'd0, 2'b10, 0, "R8 read back word0");
        chk_top("R11 lowest level in word0");
        acc(1'b1, 2'd1, 2'b11, 32'h0000_0001, "R5 el3 write");
        acc(1'b0, 2'd1, 2'b11, 0, "R6 read back word1");

        // R2: missing words
        acc(1'b0, 2'd2, 2'b11, 0, "R2 read word2");
        acc(1'b1, 2'd3, 2'b11, 32'hFFFF_FFFF, "R2 write word3");
        el2e = 1'b1; trp = 1'b1;
        acc(1'b0, 2'd3, 2'b01, 0, "R2 el1 missing word not trapped");
        acc(1'b0, 2'd0, 2'b11, 0, "R7 word0 after refused write");

        // R3: level 0
        acc(1'b0, 2'd0, 2'b00, 0, "R3 el0 read");
        acc(1'b1, 2'd1, 2'b00, 32'h1234, "R3 el0 write");

        // R4: level 1 trap and refusals
        acc(1'b0, 2'd1, 2'b01, 0, "R4 el1 trap read");
        acc(1'b1, 2'd0, 2'b01, 32'hDEAD_BEEF, "R4 el1 trap write");
        trp = 1'b0;
        acc(1'b0, 2'd0, 2'b01, 0, "R4 el1 no trap bit");
        trp = 1'b1; el2e = 1'b0;
        acc(1'b0, 2'd0, 2'b01, 0, "R4 el1 hyp disabled");

        // R5, R7: disabled interfaces
        s2 = 1'b0;
        acc(1'b1, 2'd0, 2'b10, 32'hFFFF_FFFF, "R5 el2 disabled write");
        s3 = 1'b0;
        acc(1'b0, 2'd1, 2'b11, 0, "R5 el3 disabled read");
        s3 = 1'b1;
        acc(1'b0, 2'd0, 2'b11, 0, "R7 word0 unchanged");
        acc(1'b0, 2'd1, 2'b11, 0, "R7 word1 unchanged");

        // Clear everything
        acc(1'b1, 2'd0, 2'b11, 0, "R8 clear word0");
        acc(1'b1, 2'd1, 2'b11, 0, "R8 clear word1");
        chk_top("R11 empty bank");

        // R9, R11, R12: set and clear by priority
        cyc(0, 0, 0, 0, 0, 1'b1, 8'h84, 1'b0, 8'h0, "");
        chk_top("R9 level 33 in word1");
        cyc(0, 0, 0, 0, 0, 1'b1, 8'h13, 1'b0, 8'h0, "");
        chk_top("R12 low bits dropped, level 4");
        cyc(0, 0, 0, 0, 0, 1'b0, 8'h0, 1'b1, 8'h12, "");
        chk_top("R11 back to word1 after clear");
        acc(1'b0, 2'd1, 2'b11, 0, "R9 word1 bit1");

        // R10: conflicts
        cyc(0, 0, 0, 0, 0, 1'b1, 8'h20, 1'b1, 8'h20, "");
        acc(1'b0, 2'd0, 2'b11, 0, "R10 clear beats set");
        cyc(1'b1, 1'b1, 2'd0, 2'b11, 32'h5, 1'b1, 8'h0C, 1'b0, 8'h0, "R10 write with set");
        acc(1'b0, 2'd0, 2'b11, 0, "R10 write beats set");
        cyc(1'b1, 1'b1, 2'd0, 2'b11, 32'h0, 1'b1, 8'h88, 1'b0, 8'h0, "R10 write other word");
        acc(1'b0, 2'd1, 2'b11, 0, "R10 set in other word applies");
        chk_top("R11 after conflicts");

        // Five-bit copy: R2, R9, R12
        f_v = 1; f_idx = 2'd1; f_el = 2'b11;
        @(negedge clk);
        f_v = 0;
        chk5({30'b0, fr_code}, 32'h2, "R2 five-bit word1 refused");
        fs_v = 1; fs_p = 8'h0B;
        @(negedge clk);
        fs_v = 0;
        chk5({23'b0, ft_v, ft_p}, {23'b0, 1'b1, 8'h08}, "R12 five-bit top prio");
        f_v = 1; f_idx = 2'd0;
        @(negedge clk);
        f_v = 0;
        chk5(fr_data, 32'h2, "R9 five-bit level 1");

        repeat (3) @(negedge clk);
        nchk++;
        if (exp_q.size() != 0) begin
            nbad++;
            $display("FAIL R6: pending responses=%0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule